// File: doc/BRIEF.md
# Immediate-Load Bring-Up Processor Core

This block is the smallest useful slice of an 8-bit accumulator-style processor. It reads a program byte by byte from a synchronous memory and executes one instruction class: loading an immediate byte into the accumulator (A) or one of the two index registers (X, Y). It is meant as the first milestone of a larger core. The fetch sequencing, program counter, register file and flag logic can be proven against a trivial memory image before wider decoding is added.

Execution begins at address zero straight out of reset, with no vector lookup. Each instruction is two bytes: an opcode followed by its operand. Memory answers a read one clock after the address is presented. The load into a register is retired while the next opcode is already being fetched, so the core sustains one instruction every two cycles. Any byte in opcode position that is not one of the three decoded values freezes the core until the next reset and raises a flag output. The program counter, registers and flags are brought out on observation ports.

Top module: `imm_load_core`

## Requirements
- R1: While reset (synchronous, active high) is applied and in the cycle after it is released, pcOut is 0, A, X, Y, flagN and flagZ are 0, and illegalOp is 0.
- R2: The first read after reset presents address 0. Every cycle with memRd high advances the program counter by exactly one, so opcode and operand come from consecutive addresses.
- R3: Opcode 0xA9 loads A with the byte at the following address.
- R4: Opcode 0xA2 loads X with the byte at the following address.
- R5: Opcode 0xA0 loads Y with the byte at the following address.
- R6: Every register load sets flagN to bit 7 of the loaded byte and sets flagZ exactly when the loaded byte is 0x00. flagN and flagZ are never both high.
- R7: Memory data is taken one clock after its address. The register loaded by an instruction whose opcode address was presented in cycle t shows its new value from cycle t+3, and the next opcode address is presented in cycle t+2.
- R8: An opcode other than 0xA9, 0xA2 or 0xA0 halts the core. illegalOp rises and stays high, memRd goes low, pcOut freezes at the illegal opcode's address plus one, and A, X, Y and the flags keep their values, all until reset.
- R9: Reset applied at any time, including mid-program or while halted, returns the core to the R1 state and restarts fetching at address 0.
- R10: An operand byte is never decoded. Operands equal to an opcode value or to an undecoded value are loaded as plain data and do not halt the core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | ADDR_W (16) | Read address to program memory |
| memRd | output | 1 | Read strobe; memory returns data one cycle later |
| memData | input | 8 | Read data from program memory |
| pcOut | output | ADDR_W (16) | Current program counter |
| regA | output | 8 | Accumulator |
| regX | output | 8 | X index register |
| regY | output | 8 | Y index register |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| illegalOp | output | 1 | High once an undecoded opcode has halted the core |

## Verification
The bench goes after operands equal to 0xA9, 0xA2 or 0xFF. A core that lost track of byte position would decode them and either load the wrong register or halt early. It checks 0x00 and 0x80 operands, where a swapped or stale flag update shows up as a wrong N or Z. It also checks register timing exactly two cycles per instruction, which exposes a design that samples memory data one cycle early or late and loads the opcode instead of the operand. The halt is checked over several idle cycles: a program counter that creeps on, a read strobe left high or a register that changes after the illegal opcode all fail. Reset is then applied from both the halted and mid-program states.

// File: rtl/imm_core_pkg.sv
package imm_core_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] OPC_LOAD_A = 8'hA9;
  localparam logic [DATA_W-1:0] OPC_LOAD_X = 8'hA2;
  localparam logic [DATA_W-1:0] OPC_LOAD_Y = 8'hA0;

  typedef enum logic [1:0] {
    ST_FETCH_OP  = 2'd0,
    ST_FETCH_ARG = 2'd1,
    ST_HALT      = 2'd2
  } coreState_t;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_X    = 2'd2,
    DST_Y    = 2'd3
  } loadDst_t;

  typedef struct packed {
    logic pcStep;
    logic loadA;
    logic loadX;
    logic loadY;
  } dpStrobe_t;

  function automatic loadDst_t decodeOpcode(input logic [DATA_W-1:0] opc);
    loadDst_t dst;
    case (opc)
      OPC_LOAD_A: dst = DST_A;
      OPC_LOAD_X: dst = DST_X;
      OPC_LOAD_Y: dst = DST_Y;
      default:    dst = DST_NONE;
    endcase
    return dst;
  endfunction

endpackage

// File: rtl/imm_core_ctrl.sv
module imm_core_ctrl
  import imm_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] fetchByte,
  output dpStrobe_t         strobe,
  output logic              readReq,
  output logic              haltFlag
);

  coreState_t state;
  loadDst_t   pendDst;
  loadDst_t   decDst;
  logic       decLegal;

  always_comb begin
    decDst   = decodeOpcode(fetchByte);
    decLegal = (decDst != DST_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH_OP;
      pendDst  <= DST_NONE;
      haltFlag <= 1'b0;
    end else begin
      case (state)
        ST_FETCH_OP: begin
          pendDst <= DST_NONE;
          state   <= ST_FETCH_ARG;
        end
        ST_FETCH_ARG: begin
          if (decLegal) begin
            pendDst <= decDst;
            state   <= ST_FETCH_OP;
          end else begin
            state    <= ST_HALT;
            haltFlag <= 1'b1;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    readReq = (state == ST_FETCH_OP) || ((state == ST_FETCH_ARG) && decLegal);
    strobe.pcStep = readReq;
    strobe.loadA  = (state == ST_FETCH_OP) && (pendDst == DST_A);
    strobe.loadX  = (state == ST_FETCH_OP) && (pendDst == DST_X);
    strobe.loadY  = (state == ST_FETCH_OP) && (pendDst == DST_Y);
  end

endmodule

// File: rtl/imm_core_dpath.sv
module imm_core_dpath
  import imm_core_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] accA,
  output logic [DATA_W-1:0] idxX,
  output logic [DATA_W-1:0] idxY,
  output logic              negF,
  output logic              zeroF
);

  logic anyLoad;
  assign anyLoad = strobe.loadA | strobe.loadX | strobe.loadY;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= START_PC;
      accA  <= '0;
      idxX  <= '0;
      idxY  <= '0;
      negF  <= 1'b0;
      zeroF <= 1'b0;
    end else begin
      if (strobe.pcStep) pc <= pc + 1'b1;
      if (strobe.loadA) accA <= dataIn;
      if (strobe.loadX) idxX <= dataIn;
      if (strobe.loadY) idxY <= dataIn;
      if (anyLoad) begin
        negF  <= dataIn[DATA_W-1];
        zeroF <= (dataIn == '0);
      end
    end
  end

endmodule

// File: rtl/imm_load_core.sv
module imm_load_core
  import imm_core_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [7:0]        regA,
  output logic [7:0]        regX,
  output logic [7:0]        regY,
  output logic              flagN,
  output logic              flagZ,
  output logic              illegalOp
);

  dpStrobe_t ctlStrobe;

  imm_core_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .fetchByte (memData),
    .strobe    (ctlStrobe),
    .readReq   (memRd),
    .haltFlag  (illegalOp)
  );

  imm_core_dpath #(.ADDR_W(ADDR_W), .START_PC('0)) dpath_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (ctlStrobe),
    .dataIn (memData),
    .pc     (pcOut),
    .accA   (regA),
    .idxX   (regX),
    .idxY   (regY),
    .negF   (flagN),
    .zeroF  (flagZ)
  );

  assign memAddr = pcOut;

endmodule

// File: rtl/imm_load_core_chk.sv
module imm_load_core_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              memRd,
  input logic [ADDR_W-1:0] pcOut,
  input logic [7:0]        regA,
  input logic [7:0]        regX,
  input logic [7:0]        regY,
  input logic              flagN,
  input logic              flagZ,
  input logic              illegalOp
);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    memRd |=> (pcOut == $past(pcOut) + 1'b1)); // R2

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(flagN && flagZ)); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    illegalOp |=> illegalOp); // R8

  AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> !memRd); // R8

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    illegalOp |=> ($stable(pcOut) && $stable(regA) && $stable(regX) &&
                   $stable(regY) && $stable(flagN) && $stable(flagZ))); // R8

endmodule

bind imm_load_core imm_load_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .memRd(memRd), .pcOut(pcOut), .regA(regA),
  .regX(regX), .regY(regY), .flagN(flagN), .flagZ(flagZ),
  .illegalOp(illegalOp)
);

// File: tb/imm_load_core_tb_top.sv
module imm_load_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData;
  logic [15:0] pcOut;
  logic [7:0]  regA, regX, regY;
  logic        flagN, flagZ, illegalOp;

  logic [7:0] mem [0:255];
  int checks = 0;
  int failures = 0;

  logic [7:0] progOp [0:127];
  logic [7:0] progArg [0:127];
  logic [7:0] expA, expX, expY;
  logic       expN, expZ;

  always #2 clk = ~clk;

  always @(posedge clk) if (memRd) memData <= mem[memAddr[7:0]];

  imm_load_core dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .pcOut(pcOut), .regA(regA), .regX(regX), .regY(regY),
    .flagN(flagN), .flagZ(flagZ), .illegalOp(illegalOp)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [7:0] randIllegal();
    logic [7:0] v;
    do v = 8'($urandom()); while (v == 8'hA9 || v == 8'hA2 || v == 8'hA0);
    return v;
  endfunction

  function automatic logic [7:0] randOperand();
    case ($urandom() % 6)
      0: return 8'h00;
      1: return 8'h80;
      2: return 8'hA9;
      3: return 8'hFF;
      default: return 8'($urandom());
    endcase
  endfunction

  task automatic applyReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pcOut == 16'h0 && regA == 0 && regX == 0 && regY == 0 &&
          !flagN && !flagZ && !illegalOp, "R1 reset state in reset",
          {pcOut, regA, regX}, 0);
    rst = 1'b0;
  endtask

  task automatic loadImage(input int n, input logic [7:0] badOp);
    for (int i = 0; i < 256; i++) mem[i] = 8'hEA;
    for (int i = 0; i < n; i++) begin
      mem[2*i]   = progOp[i];
      mem[2*i+1] = progArg[i];
    end
    mem[2*n] = badOp;
  endtask

  task automatic runProgram(input int n);
    applyReset();
    check(pcOut == 0 && memAddr == 0 && memRd && !illegalOp && regA == 0,
          "R1/R2 first fetch at address 0", {memAddr, 7'b0, memRd}, 32'h1);
    expA = 0; expX = 0; expY = 0; expN = 0; expZ = 0;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      case (progOp[k])
        8'hA9: expA = progArg[k];
        8'hA2: expX = progArg[k];
        default: expY = progArg[k];
      endcase
      expN = progArg[k][7];
      expZ = (progArg[k] == 8'h00);
      check(regA == expA, "R3/R7/R10 accumulator after load", regA, expA);
      check(regX == expX, "R4/R7/R10 X after load", regX, expX);
      check(regY == expY, "R5/R7/R10 Y after load", regY, expY);
      check(flagN == expN && flagZ == expZ, "R6 flags after load",
            {flagN, flagZ}, {expN, expZ});
      check(pcOut == 16'(2*k+3) && !illegalOp, "R2/R7 pc stride",
            pcOut, 2*k+3);
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(illegalOp && !memRd, "R8 halt raised, reads stopped",
          {illegalOp, memRd}, 2'b10);
    check(pcOut == 16'(2*n+1), "R8 pc frozen after illegal opcode", pcOut, 2*n+1);
    check(regA == expA && regX == expX && regY == expY &&
          flagN == expN && flagZ == expZ, "R8 state kept in halt",
          {regA, regX, regY}, {expA, expX, expY});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'hC0DE5));
    // Directed: flag extremes, operands that look like opcodes (R10)
    progOp[0] = 8'hA9; progArg[0] = 8'h80;
    progOp[1] = 8'hA2; progArg[1] = 8'h00;
    progOp[2] = 8'hA0; progArg[2] = 8'h7F;
    progOp[3] = 8'hA9; progArg[3] = 8'hA9;
    progOp[4] = 8'hA2; progArg[4] = 8'hFF;
    progOp[5] = 8'hA0; progArg[5] = 8'hA2;
    progOp[6] = 8'hA9; progArg[6] = 8'h00;
    loadImage(7, 8'h00);
    runProgram(7);

    // R9: reset out of halt
    applyReset();
    check(pcOut == 0 && memRd && !illegalOp && regA == 0 && regX == 0,
          "R9 restart after halt", {pcOut, 7'b0, illegalOp}, 0);

    // R9: reset mid-program
    repeat (7) @(posedge clk);
    @(negedge clk);
    check(regA != 0 || regX != 0, "R9 program was running before reset",
          {regA, regX}, 1);
    applyReset();
    check(pcOut == 0 && memAddr == 0 && memRd && regA == 0 && regX == 0 &&
          regY == 0 && !illegalOp, "R9 restart mid-program", pcOut, 0);

    // Immediate halt: first opcode undecoded
    loadImage(0, 8'hA1);
    runProgram(0);

    // Random programs
    for (int t = 0; t < 6; t++) begin
      int n;
      n = 1 + int'($urandom() % 60);
      for (int i = 0; i < n; i++) begin
        case ($urandom() % 3)
          0: progOp[i] = 8'hA9;
          1: progOp[i] = 8'hA2;
          default: progOp[i] = 8'hA0;
        endcase
        progArg[i] = randOperand();
      end
      loadImage(n, randIllegal());
      runProgram(n);
    end

    finishRun();
  end

endmodule